// File: doc/BRIEF.md
# Operand Hazard and Bypass Controller

This combinational controller sits beside a five-stage in-order pipeline: fetch, decode, execute, memory and write-back. Branches resolve in decode. It looks at two instructions, the one in decode and the one in execute. For each of them it takes an 8-bit operand-usage descriptor and its two source register numbers. It also takes the destination register, write flag and load flag of the instructions currently in execute, memory and write-back.

From these inputs it picks a bypass source for each of the four source operands (two in decode, two in execute). It holds fetch and decode and puts a bubble into execute whenever a required value cannot be produced in time. Each operand is either merely *wanted* (bypass it if a newer copy exists) or *needed* by a given stage (stall if the value cannot arrive by then). Because of this split, a branch compare that must have its operands in decode is treated differently from store data that is only consumed in the memory stage. For an operand that is wanted but still unavailable, a late-pickup flag tells the datapath to collect the value when the instruction reaches memory.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level-sensitive control signal, and the outputs follow the inputs within the same cycle.

Top module: `hzfw_unit`

## Requirements
- R1: Descriptor bit positions, MSB first: 7 = Rs wanted in decode, 6 = Rs needed in decode, 5 = Rt wanted in decode, 4 = Rt needed in decode, 3 = Rs wanted in execute, 2 = Rs needed in execute, 1 = Rt wanted in execute, 0 = Rt needed in execute; all active high. The decode instruction uses bits 7,6,5,4,2,0; the execute instruction uses bits 3,2,1,0.
- R2: A decode operand needed in decode whose register is written by the instruction in execute (load or not) causes a stall.
- R3: A decode operand needed in decode stalls when the instruction in memory is a load writing that register. When the memory-stage writer is not a load, the decode select is 1 (memory) and no stall results from it.
- R4: A decode operand needed in execute stalls only when the instruction in execute is a load writing that register. A non-load producer in execute does not stall it.
- R5: stall_if, stall_id and ex_bubble are always equal, and each is high exactly when some decode operand raises a stall.
- R6: Register 0 never matches a producer. It causes no stall, select 0 (none) and no late-pickup flag.
- R7: Select encoding is 0 = none, 1 = memory stage, 2 = write-back stage. The nearest writer decides. For decode operands, a writer in execute blocks any older source; then memory wins over write-back. For execute operands, memory wins over write-back. A memory writer that is a load gives select 0.
- R8: An execute operand that is wanted but not needed in execute, whose memory-stage writer is a load, raises its late-pickup flag with select 0. The flag is low in every other case.
- R9: The all-zero descriptor never stalls and never selects a bypass.
- R10: A producer whose write flag is low is ignored, whatever its destination or load flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_desc | input | 8 | Operand-usage descriptor of the decode instruction |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| ex_desc | input | 8 | Operand-usage descriptor of the execute instruction |
| ex_rs | input | REG_W | First source register of the execute instruction |
| ex_rt | input | REG_W | Second source register of the execute instruction |
| ex_dst | input | REG_W | Destination register of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_W | Destination register of the write-back instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| id_rs_sel | output | 2 | Bypass select for decode Rs |
| id_rt_sel | output | 2 | Bypass select for decode Rt |
| ex_rs_sel | output | 2 | Bypass select for execute Rs |
| ex_rt_sel | output | 2 | Bypass select for execute Rt |
| ex_rs_late | output | 1 | Execute Rs must be picked up in the memory stage |
| ex_rt_late | output | 1 | Execute Rt must be picked up in the memory stage |
| stall_if | output | 1 | Hold the fetch stage |
| stall_id | output | 1 | Hold the decode stage |
| ex_bubble | output | 1 | Insert a bubble into execute |

## Verification
The sweep targets the cases where the same register has writers in several stages. A controller that ignored the blocking effect of an execute writer would bypass a stale memory or write-back value into a branch compare. A controller that treated a memory-stage load as a valid source would hand over the load's address instead of its data. Register 0 as destination is swept against every descriptor, because a controller that forgot the zero check would stall on harmless instructions. Store-like descriptors are paired with a memory-stage load: a stall there is a lost cycle, and a missing late-pickup flag is lost store data.

// File: rtl/hzfw_pkg.sv
package hzfw_pkg;
  // bypass select codes shared by decode and execute operands
  localparam logic [1:0] SEL_NONE = 2'd0;
  localparam logic [1:0] SEL_MEM  = 2'd1;
  localparam logic [1:0] SEL_WB   = 2'd2;
  // operand slots: 0 = Rs, 1 = Rt
  localparam int OPS    = 2;
  localparam int DESC_W = 8;
  // descriptor bit positions per operand k (R1)
  function automatic int id_want_bit(int k); return 7 - 2 * k; endfunction
  function automatic int id_need_bit(int k); return 6 - 2 * k; endfunction
  function automatic int ex_want_bit(int k); return 3 - 2 * k; endfunction
  function automatic int ex_need_bit(int k); return 2 - 2 * k; endfunction
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] tag,
  input  logic [REG_W-1:0] dst,
  input  logic             wr,
  output logic             hit
);
  // a writer counts only when enabled (R10) and never for register 0 (R6)
  assign hit = wr && (dst == tag) && (tag != '0);
endmodule

// File: rtl/hz_id_operand.sv
module hz_id_operand
  import hzfw_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] tag,
  input  logic             want_id,
  input  logic             need_id,
  input  logic             need_ex,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic             hold,
  output logic [1:0]       sel
);
  logic hit_ex, hit_mem, hit_wb;

  hz_match #(.REG_W(REG_W)) u_m_ex  (.tag(tag), .dst(ex_dst),  .wr(ex_wr),  .hit(hit_ex));
  hz_match #(.REG_W(REG_W)) u_m_mem (.tag(tag), .dst(mem_dst), .wr(mem_wr), .hit(hit_mem));
  hz_match #(.REG_W(REG_W)) u_m_wb  (.tag(tag), .dst(wb_dst),  .wr(wb_wr),  .hit(hit_wb));

  always_comb begin
    // R2, R3: decode-time need; R4: load-use look-ahead for execute need
    hold = (need_id && (hit_ex || (hit_mem && mem_load)))
        || (need_ex && hit_ex && ex_load);
    // R7: nearest writer decides; an execute writer blocks older sources
    sel = SEL_NONE;
    if (want_id && !hit_ex) begin
      if (hit_mem)     sel = mem_load ? SEL_NONE : SEL_MEM;
      else if (hit_wb) sel = SEL_WB;
    end
  end

  always_comb begin
    if (tag == '0)
      assert_zero_reg_quiet_R6: assert (!hold && sel == SEL_NONE)
        else $error("register 0 produced a dependency");
    if (!need_id && !need_ex)
      assert_no_need_no_hold_R9: assert (!hold)
        else $error("stall without a needed operand");
    if (sel == SEL_MEM)
      assert_mem_sel_live_R10: assert (mem_wr && !mem_load && mem_dst == tag)
        else $error("memory bypass without a live non-load writer");
  end
endmodule

// File: rtl/hz_ex_operand.sv
module hz_ex_operand
  import hzfw_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] tag,
  input  logic             want,
  input  logic             need,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic [1:0]       sel,
  output logic             late
);
  logic hit_mem, hit_wb;

  hz_match #(.REG_W(REG_W)) u_m_mem (.tag(tag), .dst(mem_dst), .wr(mem_wr), .hit(hit_mem));
  hz_match #(.REG_W(REG_W)) u_m_wb  (.tag(tag), .dst(wb_dst),  .wr(wb_wr),  .hit(hit_wb));

  always_comb begin
    sel = SEL_NONE;
    if (want) begin
      if (hit_mem)     sel = mem_load ? SEL_NONE : SEL_MEM;
      else if (hit_wb) sel = SEL_WB;
    end
    // R8: value still in flight from a load, but only consumed later
    late = want && !need && hit_mem && mem_load;
  end

  always_comb begin
    if (late)
      assert_late_no_bypass_R8: assert (sel == SEL_NONE)
        else $error("late pickup combined with a bypass select");
    if (sel == SEL_WB)
      assert_wb_not_shadowed_R7: assert (!(mem_wr && mem_dst == tag))
        else $error("write-back chosen over a newer memory writer");
  end
endmodule

// File: rtl/hzfw_unit.sv
module hzfw_unit
  import hzfw_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [DESC_W-1:0] id_desc,
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic [DESC_W-1:0] ex_desc,
  input  logic [REG_W-1:0]  ex_rs,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic              ex_wr,
  input  logic              ex_load,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wr,
  input  logic              mem_load,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wr,
  output logic [1:0]        id_rs_sel,
  output logic [1:0]        id_rt_sel,
  output logic [1:0]        ex_rs_sel,
  output logic [1:0]        ex_rt_sel,
  output logic              ex_rs_late,
  output logic              ex_rt_late,
  output logic              stall_if,
  output logic              stall_id,
  output logic              ex_bubble
);
  logic [REG_W-1:0] id_tag [OPS];
  logic [REG_W-1:0] ex_tag [OPS];
  logic [1:0]       id_sel [OPS];
  logic [1:0]       ex_sel [OPS];
  logic [OPS-1:0]   id_hold;
  logic [OPS-1:0]   ex_late;
  logic             hazard;
  logic             unused_desc_bits;

  assign id_tag[0] = id_rs;
  assign id_tag[1] = id_rt;
  assign ex_tag[0] = ex_rs;
  assign ex_tag[1] = ex_rt;

  // the decode instruction's execute-want bits and the execute
  // instruction's decode bits carry no decision here
  assign unused_desc_bits = ^{id_desc[ex_want_bit(0)], id_desc[ex_want_bit(1)],
                              ex_desc[id_want_bit(0)], ex_desc[id_need_bit(0)],
                              ex_desc[id_want_bit(1)], ex_desc[id_need_bit(1)]};

  for (genvar k = 0; k < OPS; k++) begin : g_op
    hz_id_operand #(.REG_W(REG_W)) u_id (
      .tag(id_tag[k]),
      .want_id(id_desc[id_want_bit(k)]),
      .need_id(id_desc[id_need_bit(k)]),
      .need_ex(id_desc[ex_need_bit(k)]),
      .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
      .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
      .wb_dst(wb_dst), .wb_wr(wb_wr),
      .hold(id_hold[k]), .sel(id_sel[k])
    );
    hz_ex_operand #(.REG_W(REG_W)) u_ex (
      .tag(ex_tag[k]),
      .want(ex_desc[ex_want_bit(k)]),
      .need(ex_desc[ex_need_bit(k)]),
      .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
      .wb_dst(wb_dst), .wb_wr(wb_wr),
      .sel(ex_sel[k]), .late(ex_late[k])
    );
  end

  assign hazard     = |id_hold;
  assign stall_if   = hazard;
  assign stall_id   = hazard;
  assign ex_bubble  = hazard;
  assign id_rs_sel  = id_sel[0];
  assign id_rt_sel  = id_sel[1];
  assign ex_rs_sel  = ex_sel[0];
  assign ex_rt_sel  = ex_sel[1];
  assign ex_rs_late = ex_late[0];
  assign ex_rt_late = ex_late[1];

  always_comb begin
    if (id_desc == '0)
      assert_idle_desc_quiet_R9: assert (!stall_id && id_rs_sel == SEL_NONE && id_rt_sel == SEL_NONE)
        else $error("all-zero descriptor acted");
    if (!ex_wr && !(mem_wr && mem_load))
      assert_no_writer_no_stall_R10: assert (!stall_if)
        else $error("stall with no live producer able to cause one");
  end
endmodule

// File: tb/hzfw_unit_tb_top.sv
`timescale 1ns/1ps
module hzfw_unit_tb_top;
  localparam int RW = 2;
  localparam int NR = 1 << RW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]    id_desc, ex_desc;
  logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic          ex_wr, ex_load, mem_wr, mem_load, wb_wr;
  logic [1:0]    id_rs_sel, id_rt_sel, ex_rs_sel, ex_rt_sel;
  logic          ex_rs_late, ex_rt_late, stall_if, stall_id, ex_bubble;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  hzfw_unit #(.REG_W(RW)) dut_i (
    .id_desc(id_desc), .id_rs(id_rs), .id_rt(id_rt),
    .ex_desc(ex_desc), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
    .wb_dst(wb_dst), .wb_wr(wb_wr),
    .id_rs_sel(id_rs_sel), .id_rt_sel(id_rt_sel),
    .ex_rs_sel(ex_rs_sel), .ex_rt_sel(ex_rt_sel),
    .ex_rs_late(ex_rs_late), .ex_rt_late(ex_rt_late),
    .stall_if(stall_if), .stall_id(stall_id), .ex_bubble(ex_bubble)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  // reference: does a live writer at a stage target register t
  function automatic bit writes(logic w, logic [RW-1:0] d, logic [RW-1:0] t);
    return w && (t != 0) && (d == t);
  endfunction

  // reference decode stall for one operand (R2, R3, R4)
  function automatic bit ref_hold(logic [7:0] dsc, int k, logic [RW-1:0] t);
    bit nid = dsc[6 - 2 * k];
    bit nex = dsc[2 - 2 * k];
    bit e   = writes(ex_wr, ex_dst, t);
    bit m   = writes(mem_wr, mem_dst, t);
    if (nid && e) return 1;
    if (nid && m && mem_load) return 1;
    if (nex && e && ex_load) return 1;
    return 0;
  endfunction

  // reference select: stage order nearest first (R7)
  function automatic logic [1:0] ref_sel(bit want, bit blocked, logic [RW-1:0] t);
    if (!want || blocked) return 2'd0;
    if (writes(mem_wr, mem_dst, t)) return mem_load ? 2'd0 : 2'd1;
    if (writes(wb_wr, wb_dst, t)) return 2'd2;
    return 2'd0;
  endfunction

  task automatic compare_all(string tag);
    logic [2:0] st;
    logic [3:0] is, es;
    logic [1:0] lt;
    bit h;
    h  = ref_hold(id_desc, 0, id_rs) || ref_hold(id_desc, 1, id_rt);
    st = {3{h}};
    check({tag, " R2 R3 R4 R5 stall"}, {29'd0, stall_if, stall_id, ex_bubble}, {29'd0, st});
    is = {ref_sel(id_desc[7], writes(ex_wr, ex_dst, id_rs), id_rs),
          ref_sel(id_desc[5], writes(ex_wr, ex_dst, id_rt), id_rt)};
    check({tag, " R3 R6 R7 id_sel"}, {28'd0, id_rs_sel, id_rt_sel}, {28'd0, is});
    es = {ref_sel(ex_desc[3], 1'b0, ex_rs), ref_sel(ex_desc[1], 1'b0, ex_rt)};
    lt[1] = ex_desc[3] && !ex_desc[2] && writes(mem_wr, mem_dst, ex_rs) && mem_load;
    lt[0] = ex_desc[1] && !ex_desc[0] && writes(mem_wr, mem_dst, ex_rt) && mem_load;
    check({tag, " R7 R8 R10 ex_sel_late"}, {26'd0, ex_rs_sel, ex_rt_sel, ex_rs_late, ex_rt_late},
          {26'd0, es, lt});
  endtask

  task automatic clear_inputs();
    id_desc = 0; ex_desc = 0; id_rs = 0; id_rt = 0; ex_rs = 0; ex_rt = 0;
    ex_dst = 0; mem_dst = 0; wb_dst = 0;
    ex_wr = 0; ex_load = 0; mem_wr = 0; mem_load = 0; wb_wr = 0;
  endtask

  initial begin
    #1_500_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] dl [8];
    // none, two-reg branch, one-reg branch, store, cond move, imm shift, R-type, cp write
    dl = '{8'h00, 8'hF0, 8'hC0, 8'hAE, 8'hBC, 8'h23, 8'hAF, 8'h30};
    clear_inputs();
    #2;
    // R9: idle inputs, all-zero descriptor
    check("R9 idle stall", {29'd0, stall_if, stall_id, ex_bubble}, 32'd0);
    check("R9 idle sel", {28'd0, id_rs_sel, id_rt_sel}, 32'd0);

    // R1: only bit 7 set -> Rs bypassed from memory, Rt untouched
    id_desc = 8'h80; id_rs = 1; id_rt = 1; mem_dst = 1; mem_wr = 1; #2;
    check("R1 bit7 rs_sel", {30'd0, id_rs_sel}, 32'd1);
    check("R1 bit7 rt_sel", {30'd0, id_rt_sel}, 32'd0);
    check("R1 bit7 no stall", {31'd0, stall_id}, 32'd0);

    // R2: ALU writer in execute vs branch compare
    clear_inputs(); id_desc = 8'hF0; id_rt = 2; ex_dst = 2; ex_wr = 1; #2;
    check("R2 exec writer stall", {31'd0, stall_id}, 32'd1);
    // R5: all three hold signals together
    check("R5 triplet", {29'd0, stall_if, stall_id, ex_bubble}, 32'd7);
    // R10: same writer with write flag low
    ex_wr = 0; ex_load = 1; #2;
    check("R10 disabled writer", {29'd0, stall_if, stall_id, ex_bubble}, 32'd0);

    // R4: load in execute vs R-type needing in execute; ALU producer does not stall
    clear_inputs(); id_desc = 8'hAF; id_rs = 3; ex_dst = 3; ex_wr = 1; ex_load = 1; #2;
    check("R4 load-use stall", {31'd0, stall_id}, 32'd1);
    ex_load = 0; #2;
    check("R4 alu no stall", {31'd0, stall_id}, 32'd0);

    // R6: register 0 with every stage writing it
    clear_inputs(); id_desc = 8'hF0; ex_desc = 8'hAF;
    ex_wr = 1; ex_load = 1; mem_wr = 1; wb_wr = 1; #2;
    check("R6 reg0 stall", {31'd0, stall_id}, 32'd0);
    check("R6 reg0 sel", {26'd0, id_rs_sel, ex_rs_sel, ex_rt_sel}, 32'd0);

    // R7: memory wins over write-back for execute operand
    clear_inputs(); ex_desc = 8'hAF; ex_rs = 2; mem_dst = 2; mem_wr = 1; wb_dst = 2; wb_wr = 1; #2;
    check("R7 mem over wb", {30'd0, ex_rs_sel}, 32'd1);

    // R8: store data from a load in memory -> late pickup, no stall
    clear_inputs(); ex_desc = 8'hAE; ex_rt = 1; mem_dst = 1; mem_wr = 1; mem_load = 1; #2;
    check("R8 store late flag", {31'd0, ex_rt_late}, 32'd1);
    check("R8 store no select", {30'd0, ex_rt_sel}, 32'd0);

    // sweep: every descriptor pair offset, register pair and producer mix
    for (int di = 0; di < 8; di++)
      for (int rs = 0; rs < NR; rs++)
        for (int rt = 0; rt < NR; rt++)
          for (int ed = 0; ed < NR; ed++)
            for (int ek = 0; ek < 3; ek++)
              for (int md = 0; md < NR; md++)
                for (int mk = 0; mk < 3; mk++)
                  for (int wd = 0; wd < NR; wd++)
                    for (int wk = 0; wk < 2; wk++) begin
                      id_desc = dl[di];
                      ex_desc = dl[(di + 3) % 8];
                      id_rs = RW'(rs); id_rt = RW'(rt);
                      ex_rs = RW'(rt); ex_rt = RW'(rs);
                      ex_dst = RW'(ed); ex_wr = (ek != 0); ex_load = (ek == 2);
                      mem_dst = RW'(md); mem_wr = (mk != 0); mem_load = (mk == 2);
                      wb_dst = RW'(wd); wb_wr = (wk != 0);
                      #2;
                      compare_all("sweep");
                    end
    finish_run();
  end
endmodule